// File: doc/BRIEF.md
# Codec Control-Slot Access Controller

This block carries register traffic between a host register bus and the control registers of an audio codec on a frame-based serial link. Software first loads a data slot word and then a command slot word. Writing the command slot starts one codec register access. The direction is taken from the top bit of the command slot. The register address and the write payload are taken from fixed fields of the two slot words. Bit-serial framing is done elsewhere. On the codec side this block offers a plain request/acknowledge port into the codec register file.

A read access ends by filling two receive slot registers. One holds the echoed command word with its direction bit cleared. The other holds the returned 16-bit value, placed at the same field position that write data uses. A flags register shows whether each transmit slot is empty, whether receive data is busy or valid, and whether an access is still outstanding. Software polls these flags. While an access is outstanding, writes to either transmit slot are dropped.

Top module: `cslot_ctrl`

## Requirements
- R1: After reset the flags register (bus address 4) reads 0x07. Bit 0 is the command-slot-empty flag, bit 1 the data-slot-empty flag and bit 2 the both-empty flag. The busy flags (bits 3, 4), the valid flags (bits 5, 6) and the pending flag (bit 7) are clear. `cdc_req_o` is low and both receive slot registers read zero.
- R2: A bus write to the data slot (address 1) stores bits 19:0 of the written word, which read back at address 1. It clears the data-slot-empty flag and does not raise `cdc_req_o`.
- R3: A bus write to the command slot (address 0) stores bits 19:0, clears the command-slot-empty flag and raises `cdc_req_o` and the pending flag on the next cycle. `cdc_we_o` is the inverse of command bit 19: bit 19 = 0 means a write and 1 means a read.
- R4: `cdc_addr_o` equals command bits 18:12, and `cdc_wdata_o` equals data slot bits 19:4.
- R5: `cdc_req_o`, `cdc_we_o`, `cdc_addr_o` and `cdc_wdata_o` hold steady until `cdc_ack_i` is sampled high. `cdc_req_o` and the pending flag are low in the cycle after that.
- R6: When a read completes, the receive command slot (address 2) holds the command word with bit 19 cleared. The receive data slot (address 3) holds the 16-bit result shifted left by 4, with all other bits zero.
- R7: Launching a read sets both busy flags and clears both valid flags. Completing it clears both busy flags and sets both valid flags.
- R8: A write access leaves both receive slot registers and the busy and valid flags unchanged.
- R9: While an access is pending, bus writes to either transmit slot are ignored. The stored values and the flags do not change, and no second access is started.
- R10: When an access is acknowledged, both transmit-empty flags are set again. The both-empty flag always equals the AND of the two transmit-empty flags.
- R11: Reading the receive slot registers does not clear the valid flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| cdc_req_o | output | 1 | Access request toward the codec register file |
| cdc_we_o | output | 1 | 1 = register write, 0 = register read |
| cdc_addr_o | output | 7 | Codec register address |
| cdc_wdata_o | output | 16 | Codec register write data |
| cdc_ack_i | input | 1 | Access accepted or completed; read data valid |
| cdc_rdata_i | input | 16 | Codec register read data |

## Verification
The bench builds the block with its default parameters: a 20-bit slot, a 7-bit codec address and 16-bit codec data. With these, the direction bit sits at 19, the address field at 18:12 and the payload field at 19:4. Stimulus puts ones and zeros at exactly these field edges (all-ones commands, address 0, payload bits only in 3:0 or only in 19), so a field that is off by one bit shows up at the ports. Acknowledges are held back for several cycles, which exposes request stability and lets the bench test writes that land while an access is pending.

// File: rtl/cslot_pkg.sv
package cslot_pkg;
  typedef enum logic [2:0] {
    SEL_CMD_TX  = 3'd0,
    SEL_DATA_TX = 3'd1,
    SEL_CMD_RX  = 3'd2,
    SEL_DATA_RX = 3'd3,
    SEL_FLAGS   = 3'd4
  } reg_sel_e;

  localparam int FLAG_CMD_EMPTY  = 0;
  localparam int FLAG_DATA_EMPTY = 1;
  localparam int FLAG_BOTH_EMPTY = 2;
  localparam int FLAG_CMD_BUSY   = 3;
  localparam int FLAG_DATA_BUSY  = 4;
  localparam int FLAG_CMD_VALID  = 5;
  localparam int FLAG_DATA_VALID = 6;
  localparam int FLAG_PENDING    = 7;
  localparam int FLAGS_W         = 8;
endpackage

// File: rtl/cslot_tx_regs.sv
module cslot_tx_regs #(
  parameter int SLOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              wr_data_i,
  input  logic [SLOT_W-1:0] wdata_i,
  input  logic              sent_i,
  output logic [SLOT_W-1:0] cmd_q_o,
  output logic [SLOT_W-1:0] data_q_o,
  output logic              cmd_empty_o,
  output logic              data_empty_o
);
  logic [SLOT_W-1:0] cmd_q, data_q;
  logic              cmd_empty_q, data_empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q        <= '0;
      data_q       <= '0;
      cmd_empty_q  <= 1'b1;
      data_empty_q <= 1'b1;
    end else begin
      if (wr_cmd_i) begin
        cmd_q       <= wdata_i;
        cmd_empty_q <= 1'b0;
      end else if (sent_i) begin
        cmd_empty_q <= 1'b1;
      end
      if (wr_data_i) begin
        data_q       <= wdata_i;
        data_empty_q <= 1'b0;
      end else if (sent_i) begin
        data_empty_q <= 1'b1;
      end
    end
  end

  assign cmd_q_o      = cmd_q;
  assign data_q_o     = data_q;
  assign cmd_empty_o  = cmd_empty_q;
  assign data_empty_o = data_empty_q;

  a_r2_data_wr_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> !data_empty_q && (data_q == $past(wdata_i)));
endmodule

// File: rtl/cslot_access_fsm.sv
module cslot_access_fsm #(
  parameter int SLOT_W  = 20,
  parameter int CADDR_W = 7,
  parameter int CDATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [SLOT_W-1:0]  cmd_i,
  input  logic [SLOT_W-1:0]  data_i,
  input  logic               cdc_ack_i,
  output logic               pending_o,
  output logic               done_o,
  output logic               cdc_req_o,
  output logic               cdc_we_o,
  output logic [CADDR_W-1:0] cdc_addr_o,
  output logic [CDATA_W-1:0] cdc_wdata_o
);
  localparam int DIR_BIT  = SLOT_W - 1;
  localparam int ADDR_LSB = DIR_BIT - CADDR_W;
  localparam int DATA_LSB = SLOT_W - CDATA_W;

  logic pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pending_q <= 1'b0;
    else if (launch_i)       pending_q <= 1'b1;
    else if (cdc_ack_i)      pending_q <= 1'b0;
  end

  assign pending_o   = pending_q;
  assign done_o      = pending_q & cdc_ack_i;
  assign cdc_req_o   = pending_q;
  assign cdc_we_o    = ~cmd_i[DIR_BIT];
  assign cdc_addr_o  = cmd_i[DIR_BIT-1:ADDR_LSB];
  assign cdc_wdata_o = data_i[SLOT_W-1:DATA_LSB];

  // R5: request fields frozen until acknowledged
  a_r5_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !cdc_ack_i) |=> pending_q && $stable(cdc_addr_o) &&
                                  $stable(cdc_we_o) && $stable(cdc_wdata_o));
  a_r5_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && cdc_ack_i) |=> !pending_q);
  a_r9_no_relaunch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(launch_i && pending_q));
endmodule

// File: rtl/cslot_rx_capture.sv
module cslot_rx_capture #(
  parameter int SLOT_W  = 20,
  parameter int CDATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_rd_i,
  input  logic               done_rd_i,
  input  logic [SLOT_W-1:0]  cmd_i,
  input  logic [CDATA_W-1:0] rdata_i,
  output logic [SLOT_W-1:0]  rx_cmd_o,
  output logic [SLOT_W-1:0]  rx_data_o,
  output logic               busy_o,
  output logic               valid_o
);
  localparam int DIR_BIT  = SLOT_W - 1;
  localparam int DATA_LSB = SLOT_W - CDATA_W;

  logic [SLOT_W-1:0] rx_cmd_q, rx_data_q;
  logic              busy_q, valid_q;
  logic [SLOT_W-1:0] dir_mask;

  assign dir_mask = ~(SLOT_W'(1) << DIR_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cmd_q  <= '0;
      rx_data_q <= '0;
      busy_q    <= 1'b0;
      valid_q   <= 1'b0;
    end else if (launch_rd_i) begin
      busy_q  <= 1'b1;
      valid_q <= 1'b0;
    end else if (done_rd_i) begin
      busy_q    <= 1'b0;
      valid_q   <= 1'b1;
      rx_cmd_q  <= cmd_i & dir_mask;
      rx_data_q <= {rdata_i, {DATA_LSB{1'b0}}};
    end
  end

  assign rx_cmd_o  = rx_cmd_q;
  assign rx_data_o = rx_data_q;
  assign busy_o    = busy_q;
  assign valid_o   = valid_q;

  a_r7_busy_valid_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && valid_q));
  a_r7_done_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_rd_i |=> valid_q && !busy_q);
  a_r6_dir_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_rd_i |=> !rx_cmd_q[DIR_BIT]);
endmodule

// File: rtl/cslot_ctrl.sv
module cslot_ctrl
  import cslot_pkg::*;
#(
  parameter int REG_AW  = 3,
  parameter int BUS_W   = 32,
  parameter int SLOT_W  = 20,
  parameter int CADDR_W = 7,
  parameter int CDATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [BUS_W-1:0]   reg_wdata_i,
  output logic [BUS_W-1:0]   reg_rdata_o,
  output logic               cdc_req_o,
  output logic               cdc_we_o,
  output logic [CADDR_W-1:0] cdc_addr_o,
  output logic [CDATA_W-1:0] cdc_wdata_o,
  input  logic               cdc_ack_i,
  input  logic [CDATA_W-1:0] cdc_rdata_i
);
  localparam int DIR_BIT = SLOT_W - 1;

  logic              pending, done;
  logic              hit_cmd, hit_data, wr_cmd, wr_data;
  logic [SLOT_W-1:0] cmd_q, data_q, rx_cmd, rx_data;
  logic              cmd_empty, data_empty, rx_busy, rx_valid;
  logic [FLAGS_W-1:0] flags;

  assign hit_cmd  = reg_wr_i && (reg_addr_i == REG_AW'(SEL_CMD_TX));
  assign hit_data = reg_wr_i && (reg_addr_i == REG_AW'(SEL_DATA_TX));
  assign wr_cmd   = hit_cmd  && !pending;
  assign wr_data  = hit_data && !pending;

  cslot_tx_regs #(.SLOT_W(SLOT_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_cmd_i     (wr_cmd),
    .wr_data_i    (wr_data),
    .wdata_i      (reg_wdata_i[SLOT_W-1:0]),
    .sent_i       (done),
    .cmd_q_o      (cmd_q),
    .data_q_o     (data_q),
    .cmd_empty_o  (cmd_empty),
    .data_empty_o (data_empty)
  );

  cslot_access_fsm #(.SLOT_W(SLOT_W), .CADDR_W(CADDR_W), .CDATA_W(CDATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (wr_cmd),
    .cmd_i       (cmd_q),
    .data_i      (data_q),
    .cdc_ack_i   (cdc_ack_i),
    .pending_o   (pending),
    .done_o      (done),
    .cdc_req_o   (cdc_req_o),
    .cdc_we_o    (cdc_we_o),
    .cdc_addr_o  (cdc_addr_o),
    .cdc_wdata_o (cdc_wdata_o)
  );

  cslot_rx_capture #(.SLOT_W(SLOT_W), .CDATA_W(CDATA_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_rd_i (wr_cmd && reg_wdata_i[DIR_BIT]),
    .done_rd_i   (done && !cdc_we_o),
    .cmd_i       (cmd_q),
    .rdata_i     (cdc_rdata_i),
    .rx_cmd_o    (rx_cmd),
    .rx_data_o   (rx_data),
    .busy_o      (rx_busy),
    .valid_o     (rx_valid)
  );

  always_comb begin
    flags                  = '0;
    flags[FLAG_CMD_EMPTY]  = cmd_empty;
    flags[FLAG_DATA_EMPTY] = data_empty;
    flags[FLAG_BOTH_EMPTY] = cmd_empty & data_empty;
    flags[FLAG_CMD_BUSY]   = rx_busy;
    flags[FLAG_DATA_BUSY]  = rx_busy;
    flags[FLAG_CMD_VALID]  = rx_valid;
    flags[FLAG_DATA_VALID] = rx_valid;
    flags[FLAG_PENDING]    = pending;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_AW'(SEL_CMD_TX):  reg_rdata_o = BUS_W'(cmd_q);
      REG_AW'(SEL_DATA_TX): reg_rdata_o = BUS_W'(data_q);
      REG_AW'(SEL_CMD_RX):  reg_rdata_o = BUS_W'(rx_cmd);
      REG_AW'(SEL_DATA_RX): reg_rdata_o = BUS_W'(rx_data);
      REG_AW'(SEL_FLAGS):   reg_rdata_o = BUS_W'(flags);
      default:              reg_rdata_o = '0;
    endcase
  end

  a_r9_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cmd && pending) |=> $stable(cmd_q));
  a_r9_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_data && pending) |=> $stable(data_q));
  a_r10_sent_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> cmd_empty && data_empty);
  a_r8_write_keeps_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && cdc_we_o) |=> $stable(rx_cmd) && $stable(rx_data) && $stable(rx_valid));
  a_r3_launch_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> cdc_req_o && !cmd_empty);
endmodule

// File: tb/cslot_ctrl_bench.sv
module cslot_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        cdc_req_o, cdc_we_o;
  logic [6:0]  cdc_addr_o;
  logic [15:0] cdc_wdata_o;
  logic        cdc_ack_i = 1'b0;
  logic [15:0] cdc_rdata_i = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  localparam logic [2:0] A_CMD = 3'd0, A_DAT = 3'd1, A_RCMD = 3'd2, A_RDAT = 3'd3, A_FLG = 3'd4;

  cslot_ctrl u_cslot_ctrl (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .cdc_req_o, .cdc_we_o, .cdc_addr_o, .cdc_wdata_o, .cdc_ack_i, .cdc_rdata_i
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic ack(input logic [15:0] rdata);
    cdc_ack_i = 1'b1; cdc_rdata_i = rdata;
    @(negedge clk_i);
    cdc_ack_i = 1'b0; cdc_rdata_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_FLG, v);  chk("R1 flags", v, 32'h07);
    chk("R1 req", {31'd0, cdc_req_o}, 32'd0);
    rd(A_RCMD, v); chk("R1 rx cmd", v, 32'd0);
    rd(A_RDAT, v); chk("R1 rx data", v, 32'd0);
  endtask

  task automatic t_data_slot();
    logic [31:0] v;
    wr(A_DAT, 32'hFFFA_BCD5);
    rd(A_DAT, v);  chk("R2 data readback", v, 32'h000A_BCD5);
    rd(A_FLG, v);  chk("R2 R10 flags", v, 32'h01);
    chk("R2 no req", {31'd0, cdc_req_o}, 32'd0);
  endtask

  task automatic t_write_access();
    logic [31:0] v;
    wr(A_CMD, 32'h0005_A000);
    chk("R3 req", {31'd0, cdc_req_o}, 32'd1);
    chk("R3 we", {31'd0, cdc_we_o}, 32'd1);
    chk("R4 addr", {25'd0, cdc_addr_o}, 32'h5A);
    chk("R4 wdata", {16'd0, cdc_wdata_o}, 32'hABCD);
    rd(A_FLG, v);  chk("R3 flags", v, 32'h80);
    for (int i = 0; i < 3; i++) @(negedge clk_i);
    chk("R5 req held", {31'd0, cdc_req_o}, 32'd1);
    chk("R5 addr held", {25'd0, cdc_addr_o}, 32'h5A);
    ack(16'hFFFF);
    chk("R5 req drop", {31'd0, cdc_req_o}, 32'd0);
    rd(A_FLG, v);  chk("R10 R8 flags", v, 32'h07);
    rd(A_RDAT, v); chk("R8 rx data", v, 32'd0);
  endtask

  task automatic t_read_access();
    logic [31:0] v;
    wr(A_CMD, 32'h000F_FFFF);
    chk("R3 read we", {31'd0, cdc_we_o}, 32'd0);
    chk("R4 read addr", {25'd0, cdc_addr_o}, 32'h7F);
    rd(A_FLG, v);  chk("R7 busy flags", v, 32'h9A);
    wr(A_DAT, 32'h0001_2345);
    wr(A_CMD, 32'h0000_0000);
    rd(A_DAT, v);  chk("R9 data ignored", v, 32'h000A_BCD5);
    rd(A_CMD, v);  chk("R9 cmd ignored", v, 32'h000F_FFFF);
    rd(A_FLG, v);  chk("R9 flags", v, 32'h9A);
    ack(16'hBEEF);
    rd(A_RCMD, v); chk("R6 rx cmd", v, 32'h0007_FFFF);
    rd(A_RDAT, v); chk("R6 rx data", v, 32'h000B_EEF0);
    rd(A_FLG, v);  chk("R7 R10 flags", v, 32'h67);
    @(negedge clk_i);
    rd(A_FLG, v);  chk("R11 valid kept", v, 32'h67);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(A_CMD, 32'h0008_0000);
    chk("R4 addr zero", {25'd0, cdc_addr_o}, 32'd0);
    rd(A_FLG, v);  chk("R7 valid cleared", v, 32'h9A);
    ack(16'h0001);
    rd(A_RCMD, v); chk("R6 rx cmd edge", v, 32'd0);
    rd(A_RDAT, v); chk("R6 rx data edge", v, 32'h10);
    wr(A_DAT, 32'h0008_000F);
    wr(A_CMD, 32'hFFF0_1000);
    chk("R4 wdata edge", {16'd0, cdc_wdata_o}, 32'h8000);
    chk("R4 addr one", {25'd0, cdc_addr_o}, 32'h01);
    chk("R3 we edge", {31'd0, cdc_we_o}, 32'd1);
    rd(A_FLG, v);  chk("R8 flags pending", v, 32'hE0);
    ack(16'h1234);
    rd(A_RDAT, v); chk("R8 rx data kept", v, 32'h10);
    rd(A_FLG, v);  chk("R8 R11 flags", v, 32'h67);
  endtask

  initial begin
    for (int i = 0; i < 100000 && !finished; i++) @(posedge clk_i);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_data_slot();
    t_write_access();
    t_read_access();
    t_edges();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule